// File: doc/BRIEF.md
# Serial Bootstrap Loader Sequencer

When the boot-select pin is low at reset release, this block takes over a UART-style serial link. A host can then load a short start-up image over that link. The block first waits for the host to send one all-zero byte. It times the low part of that byte to find the bit period. It answers with a fixed identification byte. It then collects exactly 32 bytes and writes each one through a byte-write port into consecutive buffer slots. If the pin is high at reset release, the block stays out of the way: the watchdog enable is high and the transmit driver stays off.

The link is half-duplex. The transmitter works only while the identification byte is going out, and the receiver works only after that byte has finished. There is no time limit on the download, because the watchdog enable is held low for the whole time the loader owns the link.

Top module: `boot_loader_seq`

States: `S_RESET` moves to `S_SYNC_WAIT` when the pin is sampled low and to `S_OFF` when it is sampled high. `S_OFF` never changes. `S_SYNC_WAIT` moves to `S_MEASURE` on a low line. `S_MEASURE` moves back to `S_SYNC_WAIT` if the low run was too short, or to `S_GAP` when it was long enough. `S_GAP` moves to `S_SEND_ID` after one bit time. `S_SEND_ID` moves to `S_RECV` once the transmitter is idle. `S_RECV` moves to `S_DONE` on the last good byte. `S_DONE` never changes.

## Requirements
- R1: The boot-select pin is sampled on the first clock edge after reset is released. A low level enters loader mode (`loader_active`=1). A high level enters normal mode (`loader_active`=0), and normal mode stays fixed whatever the pin does afterwards; in normal mode a zero byte on `rxd` produces no transmission and no writes.
- R2: `wdt_en` is 0 for the whole time loader mode lasts, and 1 in normal mode.
- R3: In loader mode `txd_oe` is 1 and `txd` idles high.
- R4: A low run on `rxd` shorter than MIN_LOW clocks (default 18) is ignored. No identification byte follows it, and the block keeps waiting for a valid zero byte.
- R5: The bit period in clocks is the low width of the zero byte (start bit plus 8 data bits) divided by 9. One bit time after `rxd` returns high, the identification byte (default 0xC3) is sent as 8N1 at that period: a low start bit, data least significant bit first, then a high stop bit.
- R6: After the identification byte, each correctly framed received byte gives exactly one `wr_en` pulse. `wr_data` carries the byte, and `wr_addr` takes the values 0, 1, … 31 in order.
- R7: `done` rises after the stop bit of the 32nd byte and then stays high. Bytes that arrive later produce no writes.
- R8: A byte whose stop bit is sampled low sets `frame_err`, which stays set until reset. That byte is not written, and the address of the next good byte does not change.
- R9: `txd` stays high, with no transmission, for the whole time bytes are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_sel_n | input | 1 | Boot-select pin, low selects the loader |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Output enable for the transmit pin |
| wdt_en | output | 1 | Watchdog enable |
| loader_active | output | 1 | Loader mode is in effect |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 5 | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| done | output | 1 | All 32 bytes received |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The mode outputs settle one edge after reset release. The bench reads them two cycles later.

The identification start bit begins one bit time after the zero byte's stop bit starts, plus the two-flop synchroniser delay. The bench therefore does not predict that edge. It waits for `txd` to fall, then samples each bit in the middle of its period, so a wrong divisor shows up as a wrong bit.

A received byte is written about half a bit after its stop bit begins, plus three cycles. The bench records writes on falling clock edges. It checks counts and buffer contents only after the stop bit and one extra idle bit have passed.

// File: rtl/boot_pkg.sv
package boot_pkg;
    typedef enum logic [2:0] {
        S_RESET,
        S_OFF,
        S_SYNC_WAIT,
        S_MEASURE,
        S_GAP,
        S_SEND_ID,
        S_RECV,
        S_DONE
    } boot_state_t;
endpackage

// File: rtl/boot_uart_tx.sv
module boot_uart_tx #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] div,
    input  logic [7:0]    data,
    output logic          txd,
    output logic          busy
);
    logic [9:0]    shreg;
    logic [3:0]    bitn;
    logic [CW-1:0] tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            bitn  <= '0;
            tick  <= '0;
            busy  <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                shreg <= {1'b1, data, 1'b0};
                bitn  <= '0;
                tick  <= '0;
                busy  <= 1'b1;
            end
        end else if (tick == div - 1'b1) begin
            tick  <= '0;
            shreg <= {1'b1, shreg[9:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == 4'd9) busy <= 1'b0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    assign txd = busy ? shreg[0] : 1'b1;

    // R5: a start request on an idle transmitter always begins a frame
    a_r5_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !txd));
endmodule

// File: rtl/boot_uart_rx.sv
module boot_uart_rx #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rxd,
    input  logic [CW-1:0] div,
    output logic          valid,
    output logic          ferr,
    output logic [7:0]    data
);
    logic          act;
    logic          prev;
    logic [3:0]    bitn;
    logic [CW-1:0] tick;
    logic [CW-1:0] lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act   <= 1'b0;
            prev  <= 1'b1;
            bitn  <= '0;
            tick  <= '0;
            lim   <= '0;
            valid <= 1'b0;
            ferr  <= 1'b0;
            data  <= '0;
        end else begin
            valid <= 1'b0;
            ferr  <= 1'b0;
            prev  <= rxd;
            if (!act) begin
                if (en && prev && !rxd) begin
                    act  <= 1'b1;
                    tick <= '0;
                    bitn <= '0;
                    lim  <= div >> 1;
                end
            end else if (tick == lim) begin
                tick <= '0;
                lim  <= div - 1'b1;
                bitn <= bitn + 1'b1;
                if (bitn == 4'd0) begin
                    if (rxd) act <= 1'b0;
                end else if (bitn == 4'd9) begin
                    act <= 1'b0;
                    if (rxd) valid <= 1'b1;
                    else     ferr  <= 1'b1;
                end else begin
                    data <= {rxd, data[7:1]};
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    // R8: a frame ends either good or bad, never both
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && ferr));
endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq
    import boot_pkg::*;
#(
    parameter int          CW      = 16,
    parameter int          NBYTES  = 32,
    parameter logic [7:0]  ID_BYTE = 8'hC3,
    parameter int          MIN_LOW = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        boot_sel_n,
    input  logic                        rxd,
    output logic                        txd,
    output logic                        txd_oe,
    output logic                        wdt_en,
    output logic                        loader_active,
    output logic                        wr_en,
    output logic [$clog2(NBYTES)-1:0]   wr_addr,
    output logic [7:0]                  wr_data,
    output logic                        done,
    output logic                        frame_err
);
    localparam int               AW   = $clog2(NBYTES);
    localparam logic [AW-1:0]    LAST = AW'(NBYTES - 1);
    localparam logic [CW-1:0]    MINW = CW'(MIN_LOW);

    boot_state_t   state, nstate;
    logic [1:0]    sync_q;
    logic          rx_s;
    logic [CW-1:0] low_cnt;
    logic [CW-1:0] div_q;
    logic [CW-1:0] gap_cnt;
    logic [AW-1:0] byte_cnt;
    logic          err_q;
    logic          tx_start, tx_busy, tx_line;
    logic          rx_valid, rx_ferr;
    logic [7:0]    rx_data;
    logic          gap_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end
    assign rx_s    = sync_q[1];
    assign gap_end = (gap_cnt == div_q - 1'b1);

    always_comb begin
        nstate = state;
        unique case (state)
            S_RESET:     nstate = boot_sel_n ? S_OFF : S_SYNC_WAIT;
            S_OFF:       nstate = S_OFF;
            S_SYNC_WAIT: if (!rx_s) nstate = S_MEASURE;
            S_MEASURE:   if (rx_s) nstate = (low_cnt < MINW) ? S_SYNC_WAIT : S_GAP;
            S_GAP:       if (gap_end) nstate = S_SEND_ID;
            S_SEND_ID:   if (!tx_busy) nstate = S_RECV;
            S_RECV:      if (rx_valid && byte_cnt == LAST) nstate = S_DONE;
            S_DONE:      nstate = S_DONE;
            default:     nstate = S_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RESET;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            div_q    <= '0;
            gap_cnt  <= '0;
            byte_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                S_SYNC_WAIT: low_cnt <= CW'(1);
                S_MEASURE: begin
                    if (!rx_s && low_cnt != '1) low_cnt <= low_cnt + 1'b1;
                    if (rx_s) begin
                        div_q   <= low_cnt / CW'(9);
                        gap_cnt <= '0;
                    end
                end
                S_GAP: gap_cnt <= gap_cnt + 1'b1;
                S_RECV: begin
                    if (rx_valid) byte_cnt <= byte_cnt + 1'b1;
                    if (rx_ferr)  err_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign tx_start = (state == S_GAP) && gap_end;

    boot_uart_tx #(.CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .div(div_q),
        .data(ID_BYTE), .txd(tx_line), .busy(tx_busy)
    );

    boot_uart_rx #(.CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(state == S_RECV), .rxd(rx_s),
        .div(div_q), .valid(rx_valid), .ferr(rx_ferr), .data(rx_data)
    );

    always_comb begin
        loader_active = !(state == S_RESET || state == S_OFF);
        wdt_en        = (state == S_OFF);
        txd_oe        = loader_active;
        txd           = loader_active ? tx_line : 1'b1;
        wr_en         = (state == S_RECV) && rx_valid;
        wr_addr       = byte_cnt;
        wr_data       = rx_data;
        done          = (state == S_DONE);
        frame_err     = err_q;
    end

    // R1: normal mode is permanent
    a_r1_off_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF) |=> (state == S_OFF));
    // R2: watchdog held off while the loader owns the port
    a_r2_wdt_off: assert property (@(posedge clk) disable iff (!rst_n)
        loader_active |-> !wdt_en);
    // R3: transmit pin driven in loader mode
    a_r3_txd_driven: assert property (@(posedge clk) disable iff (!rst_n)
        loader_active |-> txd_oe);
    // R6: writes happen only in the receive phase
    a_r6_write_phase: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == S_RECV));
    // R7: completion is final and silent
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !wr_en));
    // R8: error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
    // R9: half duplex, no transmission while receiving
    a_r9_quiet_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECV || state == S_DONE) |-> (txd && !tx_busy));
endmodule

// File: tb/test_boot_loader_seq.sv
module test_boot_loader_seq;
    localparam logic [7:0] ID_EXP = 8'hC3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_sel_n = 1'b1;
    logic       rxd = 1'b1;
    logic       txd, txd_oe, wdt_en, loader_active, wr_en, done, frame_err;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;

    int         total = 0;
    int         bad = 0;
    int         bit_p = 20;
    int         nwr = 0;
    int         txd_lows = 0;
    int         addr_err = 0;
    logic       quiet_mon = 1'b0;
    logic [7:0] mem [32];
    logic [7:0] exp_mem [32];

    always #10 clk = ~clk;

    boot_loader_seq i_boot_loader_seq (
        .clk(clk), .rst_n(rst_n), .boot_sel_n(boot_sel_n), .rxd(rxd),
        .txd(txd), .txd_oe(txd_oe), .wdt_en(wdt_en),
        .loader_active(loader_active), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (int'(wr_addr) != nwr) addr_err++;
            mem[wr_addr] = wr_data;
            nwr++;
        end
        if (quiet_mon && !txd) txd_lows++;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst_n = 1'b0;
        boot_sel_n = sel;
        rxd = 1'b1;
        nwr = 0;
        addr_err = 0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_ok);
        rxd = 1'b0;
        wait_cyc(bit_p);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_cyc(bit_p);
        end
        rxd = stop_ok;
        wait_cyc(bit_p);
        rxd = 1'b1;
        wait_cyc(bit_p);
    endtask

    task automatic get_id(output logic [7:0] v, output logic ok);
        int t = 0;
        v = '0;
        ok = 1'b0;
        while (txd && t < 40 * bit_p) begin
            @(negedge clk);
            t++;
        end
        if (txd) return;
        wait_cyc(bit_p / 2);
        if (txd) return;
        for (int i = 0; i < 8; i++) begin
            wait_cyc(bit_p);
            v[i] = txd;
        end
        wait_cyc(bit_p);
        ok = txd;
        wait_cyc(bit_p);
    endtask

    task automatic t_normal_boot();
        do_reset(1'b1);
        check("R1 normal mode loader_active", loader_active, 0);
        check("R2 normal mode wdt_en", wdt_en, 1);
        check("R3 normal mode txd_oe", txd_oe, 0);
        boot_sel_n = 1'b0;
        bit_p = 20;
        send_byte(8'h00, 1'b1);
        wait_cyc(4 * bit_p);
        check("R1 late pin change ignored", loader_active, 0);
        check("R1 no ID in normal mode (txd lows)", txd_lows, 0);
        check("R1 no writes in normal mode", nwr, 0);
    endtask

    task automatic t_glitch();
        int lows = 0;
        do_reset(1'b0);
        check("R1 loader mode loader_active", loader_active, 1);
        check("R2 loader mode wdt_en", wdt_en, 0);
        check("R3 loader mode txd_oe", txd_oe, 1);
        check("R3 txd idles high", txd, 1);
        check("R7 done clear after reset", done, 0);
        check("R8 frame_err clear after reset", frame_err, 0);
        rxd = 1'b0;
        wait_cyc(5);
        rxd = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        check("R4 short pulse gives no ID", lows, 0);
    endtask

    task automatic t_sync_id(input int p);
        logic [7:0] v;
        logic ok;
        bit_p = p;
        rxd = 1'b0;
        wait_cyc(9 * p);
        rxd = 1'b1;
        get_id(v, ok);
        check($sformatf("R5 ID byte at period %0d", p), int'(v), int'(ID_EXP));
        check($sformatf("R5 ID stop bit at period %0d", p), int'(ok), 1);
        check("R2 wdt_en off during loader", wdt_en, 0);
    endtask

    task automatic t_download();
        int errs = 0;
        wait_cyc(2 * bit_p);
        quiet_mon = 1'b1;
        for (int i = 0; i < 32; i++) begin
            exp_mem[i] = 8'((i * 37 + 11) ^ (i << 3));
            if (i == 10) begin
                send_byte(8'h5A, 1'b0);
                check("R8 frame_err set", frame_err, 1);
                check("R8 bad byte not written", nwr, 10);
            end
            if (i == 31) check("R7 done low before last byte", done, 0);
            send_byte(exp_mem[i], 1'b1);
        end
        wait_cyc(2);
        check("R6 write count", nwr, 32);
        check("R6 address order", addr_err, 0);
        for (int i = 0; i < 32; i++)
            if (mem[i] !== exp_mem[i]) errs++;
        check("R6 buffer contents", errs, 0);
        check("R7 done after 32 bytes", done, 1);
        check("R8 frame_err still set", frame_err, 1);
        send_byte(8'hEE, 1'b1);
        check("R7 extra byte ignored", nwr, 32);
        check("R7 done stays", done, 1);
        check("R9 no txd activity while receiving", txd_lows, 0);
        quiet_mon = 1'b0;
    endtask

    task automatic t_early_bytes();
        do_reset(1'b0);
        bit_p = 16;
        send_byte(8'hFF, 1'b1);
        check("R6 byte before sync not written", nwr, 0);
        t_sync_id(33);
    endtask

    initial begin
        t_normal_boot();
        t_glitch();
        t_sync_id(20);
        t_download();
        t_early_bytes();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule